// File: doc/BRIEF.md
# GPIO interrupt cause aggregator

This block turns the 32-bit input vector of a GPIO port into four grouped interrupt requests. The vector arrives already synchronized and polarity-adjusted. Each line can raise an interrupt in two ways. As a level source, the input itself is the cause. As an edge source, a 0-to-1 transition is latched in a sticky edge-cause register until software clears it. Two mask registers decide which way, if either, each line contributes.

The per-line cause is (input AND level mask) OR (edge cause AND edge mask). Each bank of eight adjacent lines is ORed onto one registered summary output. Software reaches the three registers through a simple one-cycle write and combinational read port. The offset of the two mask registers can be moved by a parameter. Software detects both edges by flipping the upstream polarity bit after each event, so the hardware only captures rising edges.

Top module: `gpio_irq_collector`

## Requirements
- R1: After reset the edge-cause register and both mask registers read 0 and all four summary outputs are low.
- R2: An edge-cause bit is set when its input is 1 in a cycle and was 0 in the previous cycle. A falling input sets nothing. A line that is already high when reset is released is not an edge.
- R3: A write to the edge-cause register (address 0x14) clears each bit written as 0 and leaves each bit written as 1 unchanged. Set bits otherwise stay set.
- R4: A new edge arriving in the same cycle as a write that clears its bit wins, and the bit stays set.
- R5: The edge mask sits at address 0x18 + MASK_OFS and the level mask at 0x1C + MASK_OFS. Both take full writes and read back. Any other address reads 0, and a write to it changes nothing.
- R6: The cause of line n is (input[n] AND level mask[n]) OR (edge cause[n] AND edge mask[n]). With both masks at 0, no summary output rises.
- R7: Summary output g (bit g of irq) is the registered OR of the causes of lines 8g to 8g+7. It follows them one clock later.
- R8: A level-caused request lasts only while the input stays high. An edge-caused request stays up after the input falls, until its cause bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 32 | Synchronized, polarity-adjusted line levels |
| reg_addr | input | 8 | Byte address for both read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 4 | Grouped interrupt requests, one per eight lines |

## Verification
A corrupted edge-cause bit shows on the read port in the cycle after the fault. It also shows on its group's summary output one cycle after that, if the line's edge mask is set. A wrong registered copy of the inputs shows up as a missing or extra cause bit right after a 0-to-1 or 1-to-0 step on that line. A write-path or priority error appears on readback immediately after the clearing write, including one that coincides with a rising edge. A grouping error raises the wrong summary bit one clock after a masked cause appears.

// File: rtl/gpio_irq_collector.sv
module gpio_irq_collector #(
  parameter int NLINES   = 32,
  parameter int GROUP    = 8,
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NLINES-1:0]      line_in,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [NLINES-1:0]      reg_wdata,
  output logic [NLINES-1:0]      reg_rdata,
  output logic [NLINES/GROUP-1:0] irq
);
  localparam int NGRP = NLINES / GROUP;
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(8'h18 + MASK_OFS);
  localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(8'h1C + MASK_OFS);

  logic [NLINES-1:0] prev_in, edge_cause, edge_mask, lvl_mask, rise, line_cause;
  logic [NGRP-1:0]   grp_any;
  logic              wr_cause;

  assign rise       = line_in & ~prev_in;
  assign wr_cause   = reg_wr && (reg_addr == A_CAUSE);
  assign line_cause = (line_in & lvl_mask) | (edge_cause & edge_mask);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |line_cause[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_in    <= '1;
      edge_cause <= '0;
      edge_mask  <= '0;
      lvl_mask   <= '0;
      irq        <= '0;
    end else begin
      prev_in    <= line_in;
      edge_cause <= (wr_cause ? (edge_cause & reg_wdata) : edge_cause) | rise;
      if (reg_wr && reg_addr == A_EMASK) edge_mask <= reg_wdata;
      if (reg_wr && reg_addr == A_LMASK) lvl_mask  <= reg_wdata;
      irq        <= grp_any;
    end
  end

  always_comb begin
    if      (reg_addr == A_CAUSE) reg_rdata = edge_cause;
    else if (reg_addr == A_EMASK) reg_rdata = edge_mask;
    else if (reg_addr == A_LMASK) reg_rdata = lvl_mask;
    else                          reg_rdata = '0;
  end

  assert_edge_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (edge_cause & $past(rise)) == $past(rise));

  assert_cause_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> (edge_cause & $past(edge_cause)) == $past(edge_cause));

  assert_cause_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> (edge_cause & ~$past(reg_wdata) & ~$past(rise)) == '0);

  assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && |(rise & ~reg_wdata)) |=> |(edge_cause & $past(rise & ~reg_wdata)));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mask == '0 && lvl_mask == '0) |=> irq == '0);
endmodule

// File: tb/test_gpio_irq_collector.sv
module test_gpio_irq_collector;
  logic        clk = 0, rst_n = 0;
  logic [31:0] line_in = 0, reg_wdata = 0, reg_rdata;
  logic [7:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [3:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_prev = '1, m_cause = 0, m_em = 0, m_lm = 0;
  logic [3:0]  m_irq = 0;

  gpio_irq_collector i_gpio_irq_collector (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h14: return m_cause;
      8'h18: return m_em;
      8'h1C: return m_lm;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] model_groups(input logic [31:0] din);
    logic [31:0] c;
    logic [3:0]  r;
    c = (din & m_lm) | (m_cause & m_em);
    for (int g = 0; g < 4; g++) r[g] = |c[g*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] din, input logic wr, input logic [7:0] a,
                      input logic [31:0] wd, input string tag);
    logic [31:0] rise, nc;
    logic [3:0]  ni;
    @(negedge clk);
    line_in = din; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    rise = din & ~m_prev;
    nc = ((wr && a == 8'h14) ? (m_cause & wd) : m_cause) | rise;
    ni = model_groups(din);
    @(posedge clk);
    m_prev = din; m_cause = nc; m_irq = ni;
    if (wr && a == 8'h18) m_em = wd;
    if (wr && a == 8'h1C) m_lm = wd;
    #1;
    check({tag, " irq R7"}, {28'h0, irq}, {28'h0, m_irq});
    check({tag, " read"}, reg_rdata, model_read(a));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [5];
    addrs = '{8'h14, 8'h18, 8'h1C, 8'h10, 8'h00};
    void'($urandom(32'd1234));
    line_in = 32'h0000_00F0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state; R2 high-at-reset line is no edge
    step(32'h0000_00F0, 0, 8'h14, 0, "R1 R2 cause after reset");
    check("R1 irq", {28'h0, irq}, 32'h0);
    step(32'h0000_00F0, 0, 8'h18, 0, "R1 edge mask");
    step(32'h0000_00F0, 0, 8'h1C, 0, "R1 level mask");
    // R6 nothing masked: edges give no irq
    step(32'h8000_0100, 0, 8'h14, 0, "R6 unmasked edge");
    check("R6 no irq", {28'h0, irq}, 32'h0);
    step(32'h0, 0, 8'h14, 0, "R2 falling no edge");
    // R5 mask writes and readback, junk address
    step(32'h0, 1, 8'h18, 32'h8000_0001, "R5 edge mask write");
    step(32'h0, 1, 8'h10, 32'hFFFF_FFFF, "R5 junk write");
    step(32'h0, 0, 8'h18, 0, "R5 edge mask readback");
    check("R7 group3 from old edge", {28'h0, irq}, 32'h8);
    // R3 clear bit 31 keep bit 8 via write-1
    step(32'h0, 1, 8'h14, 32'h0000_0100, "R3 partial clear");
    step(32'h0, 0, 8'h14, 0, "R3 after clear");
    check("R3 cause value", reg_rdata, 32'h0000_0100);
    // R4 edge coincides with clear
    step(32'h0000_0001, 1, 8'h14, 32'h0, "R4 edge vs clear");
    check("R4 bit0 kept", reg_rdata, 32'h0000_0001);
    step(32'h0, 0, 8'h14, 0, "R8 edge irq after input falls");
    check("R8 edge irq held", {28'h0, irq}, 32'h1);
    step(32'h0, 1, 8'h14, 32'h0, "R3 clear all");
    // R8 level
    step(32'h0, 1, 8'h1C, 32'h0001_0000, "R8 level mask");
    step(32'h0001_0000, 0, 8'h1C, 0, "R8 level high");
    step(32'h0001_0000, 0, 8'h1C, 0, "R8 level held");
    check("R8 level irq", {28'h0, irq}, 32'h4);
    step(32'h0, 0, 8'h1C, 0, "R8 level drop");
    step(32'h0, 0, 8'h1C, 0, "R8 level gone");
    check("R8 level irq gone", {28'h0, irq}, 32'h0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d, w;
      logic [7:0]  a;
      d = $urandom & $urandom;
      a = addrs[$urandom_range(0, 4)];
      w = (a == 8'h14) ? ($urandom | $urandom) : $urandom;
      step(d, ($urandom_range(0, 3) == 0), a, w, "R2 R3 R4 R5 R6 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule